// File: doc/BRIEF.md
# CSR Access Permission and Read-Modify-Write Unit

This block sits in front of the control and status register file and turns one CSR instruction into a permission verdict, a value returned to the destination register, and a merged write for the register file. It decodes the required privilege and the read-only status from the 12-bit address. It applies a debugger override and a per-address predicate supplied by the register file. It converts the four instruction flavours (read, write, set, clear) into a write value and a write mask.

Two trap-vector registers are held inside the block, one for machine level and one for supervisor level. A write to either is accepted only when it selects a defined vectoring mode. The three floating-point control addresses are gated by the floating-point state field. Any legal write to them requests that the field be marked dirty, and their write data is trimmed to the width of the fields they hold. The verdict and all strobes are combinational from the request. Only the trap-vector registers are clocked.

Top module: `csr_access_unit`

## Requirements
- R1: The privilege an address needs is its bits [9:8]. A request is illegal when `priv_i` is below it, unless `debug_i` is 1.
- R2: Addresses with bits [11:10] = 2'b11 are read-only. A request to one is illegal when its write mask is nonzero, and legal when the mask is zero.
- R3: `op_i` encoding: 2'b00 read (mask 0), 2'b01 write (new value `src_i`, mask all ones), 2'b10 set (new value all ones, mask `src_i`), 2'b11 clear (new value 0, mask `src_i`).
- R4: `wdata_o` = (old & ~mask) | (new & mask). `we_o` is 1 only for a legal valid request with a nonzero mask whose address is not a trap vector.
- R5: `old_o` always carries the value the register held before the request, also when a write takes place.
- R6: A request is illegal when `pred_ok_i` is 0. It is also illegal when `has_read_i` is 0, except at the two trap-vector addresses.
- R7: The trap vectors at 12'h305 and 12'h105 are held inside the block and reset to `TVEC_RESET` (default 0). A legal write with a nonzero mask updates one only when the merged data bits [1:0] are 2'b00 or 2'b01. Any other value leaves it unchanged. The new value appears on `old_o` from the next cycle on.
- R8: The floating-point addresses 12'h001 (flags), 12'h002 (rounding mode) and 12'h003 (combined) are illegal when `fs_i` = 2'b00, unless `debug_i` is 1.
- R9: `fs_dirty_o` is 1 only for a legal valid request with a nonzero mask to a floating-point address.
- R10: `wdata_o` is trimmed for the floating-point addresses: to bits [4:0] for 12'h001, to bits [2:0] for 12'h002, and to bits [7:0] for 12'h003, where the combined register holds the flags in [4:0] and the rounding mode in [7:5].
- R11: With `req_valid_i` at 0, `illegal_o`, `we_o` and `fs_dirty_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A CSR request is present |
| csr_addr_i | input | 12 | CSR address |
| priv_i | input | 2 | Current privilege level |
| debug_i | input | 1 | Request issued by the debugger |
| op_i | input | 2 | Operation: read, write, set, clear |
| src_i | input | XLEN | Source operand |
| pred_ok_i | input | 1 | Per-address predicate from the register file |
| has_read_i | input | 1 | Register file has a read accessor for the address |
| fs_i | input | 2 | Floating-point state field |
| rf_rdata_i | input | XLEN | Current register file value at the address |
| illegal_o | output | 1 | Request is an illegal access |
| old_o | output | XLEN | Previous value for the destination register |
| wdata_o | output | XLEN | Merged write data |
| we_o | output | 1 | Register file write enable |
| fs_dirty_o | output | 1 | Request to mark floating-point state dirty |

## Verification
The merge is tried with write, set and clear over operands whose ones and zeros overlap the old value in different places. This separates a correct mask from one that swaps the new value and the mask. A set with a zero operand shows that the write enable follows the mask and not the operation. Privilege, read-only and predicate patterns are each applied alone and then with the debugger flag, so that each source of illegality is seen on its own. Trap-vector writes alternate between defined and reserved modes, and the stored value is read back in the following cycle. This tells a filtered write from a dropped or an unfiltered one.

// File: rtl/csr_access_pkg.sv
package csr_access_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef enum logic [1:0] {
    FPK_NONE  = 2'b00,
    FPK_FLAGS = 2'b01,
    FPK_RMODE = 2'b10,
    FPK_CTRL  = 2'b11
  } fp_kind_e;

  localparam logic [11:0] ADDR_FP_FLAGS = 12'h001;
  localparam logic [11:0] ADDR_FP_RMODE = 12'h002;
  localparam logic [11:0] ADDR_FP_CTRL  = 12'h003;
  localparam logic [11:0] ADDR_TVEC_M   = 12'h305;
  localparam logic [11:0] ADDR_TVEC_S   = 12'h105;

  localparam int unsigned FLAG_W  = 5;
  localparam int unsigned RMODE_W = 3;
  localparam int unsigned CTRL_W  = FLAG_W + RMODE_W;
  localparam int unsigned N_TVEC  = 2;
endpackage

// File: rtl/csr_perm_check.sv
module csr_perm_check (
  input  logic        valid_i,
  input  logic [11:0] addr_i,
  input  logic [1:0]  priv_i,
  input  logic        debug_i,
  input  logic        mask_nz_i,
  input  logic        pred_ok_i,
  input  logic        has_read_i,
  input  logic        internal_hit_i,
  input  logic        fp_hit_i,
  input  logic [1:0]  fs_i,
  output logic        illegal_o
);
  logic priv_fail, ro_fail, pred_fail, fp_fail;

  always_comb begin
    priv_fail = !debug_i && (priv_i < addr_i[9:8]);
    ro_fail   = (addr_i[11:10] == 2'b11) && mask_nz_i;
    pred_fail = !pred_ok_i || (!has_read_i && !internal_hit_i);
    fp_fail   = fp_hit_i && (fs_i == 2'b00) && !debug_i;
    illegal_o = valid_i && (priv_fail || ro_fail || pred_fail || fp_fail);
  end
endmodule

// File: rtl/csr_rmw.sv
module csr_rmw
  import csr_access_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  csr_op_e          op_i,
  input  fp_kind_e         fp_kind_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic [XLEN-1:0]  old_i,
  output logic             mask_nz_o,
  output logic [XLEN-1:0]  wdata_o
);
  logic [XLEN-1:0] mask, newv, keep, merged;

  always_comb begin
    unique case (op_i)
      OP_WRITE: begin newv = src_i;      mask = '1;    end
      OP_SET:   begin newv = '1;         mask = src_i; end
      OP_CLEAR: begin newv = '0;         mask = src_i; end
      default:  begin newv = '0;         mask = '0;    end
    endcase
    unique case (fp_kind_i)
      FPK_FLAGS: keep = XLEN'((1 << FLAG_W) - 1);
      FPK_RMODE: keep = XLEN'((1 << RMODE_W) - 1);
      FPK_CTRL:  keep = XLEN'((1 << CTRL_W) - 1);
      default:   keep = '1;
    endcase
    merged    = (old_i & ~mask) | (newv & mask);
    wdata_o   = merged & keep;
    mask_nz_o = |mask;
  end
endmodule

// File: rtl/csr_tvec_bank.sv
module csr_tvec_bank #(
  parameter int unsigned          XLEN       = 32,
  parameter int unsigned          N          = 2,
  parameter logic [XLEN-1:0]      TVEC_RESET = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N-1:0]           wr_req_i,
  input  logic [XLEN-1:0]        wdata_i,
  output logic [N-1:0][XLEN-1:0] q_o
);
  // only direct (0) and vectored (1) modes are accepted
  logic mode_ok;
  assign mode_ok = (wdata_i[1:0] == 2'b00) || (wdata_i[1:0] == 2'b01);

  for (genvar i = 0; i < N; i++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     q_o[i] <= TVEC_RESET;
      else if (wr_req_i[i] && mode_ok) q_o[i] <= wdata_i;
    end

    p_tvec_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_i[i] && wdata_i[1]) |=> $stable(q_o[i]));
    p_tvec_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_i[i] && !wdata_i[1]) |=> (q_o[i] == $past(wdata_i)));
  end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_access_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] TVEC_RESET = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [11:0]      csr_addr_i,
  input  logic [1:0]       priv_i,
  input  logic             debug_i,
  input  logic [1:0]       op_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic             pred_ok_i,
  input  logic             has_read_i,
  input  logic [1:0]       fs_i,
  input  logic [XLEN-1:0]  rf_rdata_i,
  output logic             illegal_o,
  output logic [XLEN-1:0]  old_o,
  output logic [XLEN-1:0]  wdata_o,
  output logic             we_o,
  output logic             fs_dirty_o
);
  logic [N_TVEC-1:0]            tvec_hit;
  logic [N_TVEC-1:0]            tvec_wr;
  logic [N_TVEC-1:0][XLEN-1:0]  tvec_q;
  logic                         any_tvec, fp_hit, mask_nz, write_ok;
  fp_kind_e                     fp_kind;

  always_comb begin
    tvec_hit[0] = (csr_addr_i == ADDR_TVEC_M);
    tvec_hit[1] = (csr_addr_i == ADDR_TVEC_S);
    any_tvec    = |tvec_hit;
    unique case (csr_addr_i)
      ADDR_FP_FLAGS: fp_kind = FPK_FLAGS;
      ADDR_FP_RMODE: fp_kind = FPK_RMODE;
      ADDR_FP_CTRL:  fp_kind = FPK_CTRL;
      default:       fp_kind = FPK_NONE;
    endcase
    fp_hit = (fp_kind != FPK_NONE);
    old_o  = rf_rdata_i;
    for (int i = 0; i < N_TVEC; i++)
      if (tvec_hit[i]) old_o = tvec_q[i];
  end

  csr_rmw #(.XLEN(XLEN)) u_rmw (
    .op_i      (csr_op_e'(op_i)),
    .fp_kind_i (fp_kind),
    .src_i     (src_i),
    .old_i     (old_o),
    .mask_nz_o (mask_nz),
    .wdata_o   (wdata_o)
  );

  csr_perm_check u_perm (
    .valid_i        (req_valid_i),
    .addr_i         (csr_addr_i),
    .priv_i         (priv_i),
    .debug_i        (debug_i),
    .mask_nz_i      (mask_nz),
    .pred_ok_i      (pred_ok_i),
    .has_read_i     (has_read_i),
    .internal_hit_i (any_tvec),
    .fp_hit_i       (fp_hit),
    .fs_i           (fs_i),
    .illegal_o      (illegal_o)
  );

  assign write_ok   = req_valid_i && !illegal_o && mask_nz;
  assign we_o       = write_ok && !any_tvec;
  assign fs_dirty_o = write_ok && fp_hit;
  assign tvec_wr    = write_ok ? tvec_hit : '0;

  csr_tvec_bank #(.XLEN(XLEN), .N(N_TVEC), .TVEC_RESET(TVEC_RESET)) u_tvec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (tvec_wr),
    .wdata_i  (wdata_o),
    .q_o      (tvec_q)
  );

  p_we_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (!illegal_o && req_valid_i));
  p_ro_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (csr_addr_i[11:10] != 2'b11));
  p_priv_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !debug_i && (priv_i < csr_addr_i[9:8])) |-> illegal_o);
  p_fs_dirty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_dirty_o |-> (!illegal_o && fp_hit && !we_o == 1'b0));
  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!illegal_o && !we_o && !fs_dirty_o));
  p_fp_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && fp_hit && fs_i == 2'b00 && !debug_i) |-> illegal_o);
endmodule

// File: tb/csr_access_unit_test.sv
module csr_access_unit_test;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic [11:0]     csr_addr_i = '0;
  logic [1:0]      priv_i = '0;
  logic            debug_i = 1'b0;
  logic [1:0]      op_i = '0;
  logic [XLEN-1:0] src_i = '0;
  logic            pred_ok_i = 1'b1;
  logic            has_read_i = 1'b1;
  logic [1:0]      fs_i = '0;
  logic [XLEN-1:0] rf_rdata_i = '0;
  logic            illegal_o, we_o, fs_dirty_o;
  logic [XLEN-1:0] old_o, wdata_o;

  always #5 clk = ~clk;

  csr_access_unit #(.XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .csr_addr_i(csr_addr_i), .priv_i(priv_i), .debug_i(debug_i),
    .op_i(op_i), .src_i(src_i), .pred_ok_i(pred_ok_i),
    .has_read_i(has_read_i), .fs_i(fs_i), .rf_rdata_i(rf_rdata_i),
    .illegal_o(illegal_o), .old_o(old_o), .wdata_o(wdata_o),
    .we_o(we_o), .fs_dirty_o(fs_dirty_o)
  );

  typedef struct {
    logic            ill;
    logic            we;
    logic            fsd;
    logic [XLEN-1:0] old;
    logic [XLEN-1:0] wd;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  logic [XLEN-1:0] tvm_model = '0;
  logic [XLEN-1:0] tvs_model = '0;

  task automatic check_bit(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_word(string tag, string what, logic [XLEN-1:0] act,
                            logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic drive(string tag, logic v, logic [11:0] a, logic [1:0] p,
                       logic d, logic [1:0] o, logic [XLEN-1:0] s,
                       logic pr, logic hr, logic [1:0] f, logic [XLEN-1:0] rd);
    exp_t e;
    logic [XLEN-1:0] mask, newv, merged, keep;
    logic tv_m, tv_s, tv, fp;
    @(posedge clk); #1;
    req_valid_i = v; csr_addr_i = a; priv_i = p; debug_i = d; op_i = o;
    src_i = s; pred_ok_i = pr; has_read_i = hr; fs_i = f; rf_rdata_i = rd;
    case (o)
      2'b01:   begin newv = s;  mask = '1; end
      2'b10:   begin newv = '1; mask = s;  end
      2'b11:   begin newv = '0; mask = s;  end
      default: begin newv = '0; mask = '0; end
    endcase
    tv_m = (a == 12'h305);
    tv_s = (a == 12'h105);
    tv   = tv_m || tv_s;
    fp   = (a == 12'h001) || (a == 12'h002) || (a == 12'h003);
    e.old = tv_m ? tvm_model : (tv_s ? tvs_model : rd);
    e.ill = v && ((!d && p < a[9:8]) || (a[11:10] == 2'b11 && mask != 0) ||
                  !pr || (!hr && !tv) || (fp && f == 2'b00 && !d));
    merged = (e.old & ~mask) | (newv & mask);
    keep = (a == 12'h001) ? 32'h1F : (a == 12'h002) ? 32'h7 :
           (a == 12'h003) ? 32'hFF : 32'hFFFF_FFFF;
    e.wd  = merged & keep;
    e.we  = v && !e.ill && mask != 0 && !tv;
    e.fsd = v && !e.ill && fp && mask != 0;
    e.tag = tag;
    exp_q.push_back(e);
    if (v && !e.ill && mask != 0 && tv && merged[1:0] < 2) begin
      if (tv_m) tvm_model = merged;
      else      tvs_model = merged;
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check_bit(e.tag, "illegal", illegal_o, e.ill);
      check_bit(e.tag, "we", we_o, e.we);
      check_bit(e.tag, "fs_dirty", fs_dirty_o, e.fsd);
      check_word(e.tag, "old", old_o, e.old);
      if (e.we || e.fsd) check_word(e.tag, "wdata", wdata_o, e.wd);
    end
  end

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // reset state, idle outputs
    drive("R11_reset_idle", 0, 12'h340, 0, 0, 2'b01, 32'h1, 0, 0, 0, 32'h0);
    drive("R7_reset_mtvec", 1, 12'h305, 3, 0, 2'b00, 0, 1, 1, 0, 32'hAAAA);
    drive("R7_reset_stvec", 1, 12'h105, 3, 0, 2'b00, 0, 1, 1, 0, 32'hAAAA);
    // merge patterns
    drive("R3_R4_R5_write", 1, 12'h340, 3, 0, 2'b01, 32'hDEADBEEF, 1, 1, 0, 32'h12345678);
    drive("R3_R4_set",      1, 12'h340, 3, 0, 2'b10, 32'h000000F0, 1, 1, 0, 32'h0F00000F);
    drive("R3_R4_clear",    1, 12'h340, 3, 0, 2'b11, 32'h0000000F, 1, 1, 0, 32'h0F0000FF);
    drive("R4_set_zero",    1, 12'h340, 3, 0, 2'b10, 32'h0, 1, 1, 0, 32'h55AA55AA);
    drive("R3_read",        1, 12'h340, 3, 0, 2'b00, 32'hFFFFFFFF, 1, 1, 0, 32'h13572468);
    // privilege
    drive("R1_low_priv",    1, 12'h340, 1, 0, 2'b01, 32'h1, 1, 1, 0, 32'h0);
    drive("R1_debug",       1, 12'h340, 0, 1, 2'b01, 32'h1, 1, 1, 0, 32'h0);
    drive("R1_super_ok",    1, 12'h140, 1, 0, 2'b01, 32'h77, 1, 1, 0, 32'h0);
    drive("R1_user_fail",   1, 12'h140, 0, 0, 2'b00, 32'h0, 1, 1, 0, 32'h9);
    // read-only
    drive("R2_ro_read",     1, 12'hC00, 0, 0, 2'b00, 32'h0, 1, 1, 0, 32'h0000BEEF);
    drive("R2_ro_set",      1, 12'hC00, 0, 0, 2'b10, 32'h1, 1, 1, 0, 32'h0);
    drive("R2_ro_write",    1, 12'hF14, 3, 1, 2'b01, 32'h0, 1, 1, 0, 32'h0);
    drive("R2_ro_clear0",   1, 12'hF14, 3, 0, 2'b11, 32'h0, 1, 1, 0, 32'h4);
    // predicate
    drive("R6_pred_fail",   1, 12'h340, 3, 1, 2'b01, 32'h1, 0, 1, 0, 32'h0);
    drive("R6_no_read",     1, 12'h340, 3, 0, 2'b00, 32'h0, 1, 0, 0, 32'h0);
    drive("R6_tvec_noread", 1, 12'h305, 3, 0, 2'b00, 32'h0, 1, 0, 0, 32'h0);
    // trap vectors
    drive("R7_mtvec_vect",  1, 12'h305, 3, 0, 2'b01, 32'h80000001, 1, 1, 0, 32'h0);
    drive("R7_mtvec_rb",    1, 12'h305, 3, 0, 2'b00, 32'h0, 1, 1, 0, 32'h0);
    drive("R7_mtvec_rsv2",  1, 12'h305, 3, 0, 2'b01, 32'h00001002, 1, 1, 0, 32'h0);
    drive("R7_mtvec_rsv3",  1, 12'h305, 3, 0, 2'b01, 32'h00000003, 1, 1, 0, 32'h0);
    drive("R7_mtvec_hold",  1, 12'h305, 3, 0, 2'b00, 32'h0, 1, 1, 0, 32'h0);
    drive("R7_stvec_set",   1, 12'h105, 1, 0, 2'b10, 32'h00000100, 1, 1, 0, 32'h0);
    drive("R7_stvec_clr",   1, 12'h105, 1, 0, 2'b11, 32'h00000100, 1, 1, 0, 32'h0);
    drive("R7_stvec_rb",    1, 12'h105, 1, 0, 2'b00, 32'h0, 1, 1, 0, 32'h0);
    drive("R7_stvec_lowpr", 1, 12'h105, 0, 0, 2'b01, 32'h4, 1, 1, 0, 32'h0);
    drive("R7_stvec_rb2",   1, 12'h105, 1, 0, 2'b00, 32'h0, 1, 1, 0, 32'h0);
    // floating point gating
    drive("R8_fs_off",      1, 12'h001, 0, 0, 2'b00, 32'h0, 1, 1, 0, 32'h3);
    drive("R8_fs_off_dbg",  1, 12'h001, 0, 1, 2'b01, 32'hFFFFFFFF, 1, 1, 0, 32'h3);
    drive("R8_R9_fs_on",    1, 12'h002, 0, 0, 2'b01, 32'h5, 1, 1, 1, 32'h0);
    drive("R9_fp_read",     1, 12'h003, 0, 0, 2'b00, 32'h0, 1, 1, 2, 32'h0000002A);
    drive("R9_fp_set0",     1, 12'h003, 0, 0, 2'b10, 32'h0, 1, 1, 3, 32'h0);
    drive("R10_ctrl_trim",  1, 12'h003, 0, 0, 2'b01, 32'hFFFFFFFF, 1, 1, 1, 32'h0);
    drive("R10_flag_trim",  1, 12'h001, 0, 0, 2'b10, 32'hFFFFFFFF, 1, 1, 1, 32'h0);
    drive("R10_rm_trim",    1, 12'h002, 0, 0, 2'b01, 32'h000000FF, 1, 1, 1, 32'h0);
    drive("R10_ctrl_clr",   1, 12'h003, 0, 0, 2'b11, 32'h00000021, 1, 1, 1, 32'h000001FF);
    // idle with every failing input present
    drive("R11_idle_fail",  0, 12'h001, 0, 0, 2'b01, 32'h1, 0, 0, 0, 32'h0);
    drive("R11_idle_tvec",  0, 12'h305, 3, 0, 2'b01, 32'h8, 1, 1, 0, 32'h0);
    drive("R7_after_idle",  1, 12'h305, 3, 0, 2'b00, 32'h0, 1, 1, 0, 32'h0);
    @(posedge clk); #1 req_valid_i = 1'b0;
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule